// File: doc/BRIEF.md
# Three-Byte Framed SPI Register Slave

This block is an SPI slave that runs entirely on a fast system clock. It oversamples the serial clock, the active-low select and the serial data input through synchronizers, and detects their edges in the system clock domain. A transaction is a packet of three bytes: a command byte, then a register index byte, then a payload byte. Each byte is framed by its own select-low period. A byte is accepted only when select rises again after the right number of rising serial-clock edges.

The slave holds a read-only 8-bit channel status value, taken from an input port, and four writable 8-bit debounce configuration registers. The configuration registers are presented on two flattened output buses: one holds the filter mode pairs and one holds the delay pairs, two bits per channel.

A rising serial-clock edge seen while select is high abandons any packet in progress, so a master can always resynchronize. The serial output is driven, with a separate enable, only during the payload byte of a read that addresses this device.

Top module: `framed_spi_regs`

## Requirements
- R1: After reset all four configuration registers are zero, so `modeCfg` and `dlyCfg` read zero, and `misoOe` is low.
- R2: Bits are captured MSB first on rising serial-clock edges while select is low. A command or index byte is accepted only when select rises after exactly eight rising edges. A byte with fewer or more edges is discarded, and the next byte is taken for the same packet position.
- R3: A rising serial-clock edge while select is high abandons the packet, so the next byte is treated as a command byte.
- R4: The command byte carries broadcast in bit 7 and read(1)/write(0) in bit 6; bits 5:4 are ignored and bits 3:0 are the device ID. Index 0 reads `chanStatus`. Indices 1 and 2 hold the mode pairs for channels 3..0 and 7..4, on `modeCfg[7:0]` and `modeCfg[15:8]`. Indices 3 and 4 hold the delay pairs for the same channels, on `dlyCfg[7:0]` and `dlyCfg[15:8]`. Channel n uses bits 2n+1:2n.
- R5: A read of any other index, 5 to 255, returns 0x00. A write to index 0 or to any index above 4 changes no register.
- R6: `misoOe` is high only during the payload byte of a read. It is low during command and index bytes, during every byte of a write, and between packets.
- R7: A write commits when broadcast is set or the device ID is zero. A read drives data only when the device ID is zero, whatever the broadcast bit holds.
- R8: A payload byte that ends with fewer than eight rising edges leaves every register unchanged.
- R9: A write payload byte with more than eight rising edges commits its first eight bits when select rises.
- R10: Read data is loaded when select falls for the payload byte, with the MSB on `misoOut` at once. It advances one bit on each falling serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from the master, asynchronous |
| nssIn | input | 1 | Active-low select, asynchronous |
| mosiIn | input | 1 | Serial data from the master |
| chanStatus | input | 8 | Live channel levels returned at index 0 |
| misoOut | output | 1 | Serial read data |
| misoOe | output | 1 | Output enable for the serial read data |
| modeCfg | output | 16 | Filter mode pair per channel |
| dlyCfg | output | 16 | Delay pair per channel |

## Verification
The assertions assume that every level on the serial clock, select and data inputs lasts at least three system clocks, so the synchronizers see each edge once. They also assume that select and the serial clock never change in the same system clock. The stimulus keeps each serial half period at eight system clocks and moves select only while the serial clock is low and settled. The stimulus sweeps every device ID with the broadcast bit both clear and set, and reads a spread of mapped and unmapped indices. It also covers short bytes, long bytes and resync pulses at each packet position.

// File: rtl/fspi_pkg.sv
package fspi_pkg;
  localparam int BYTE_W    = 8;
  localparam int BCAST_BIT = 7;
  localparam int RW_BIT    = 6;
  localparam int CID_W     = 4;

  typedef enum logic [1:0] {
    PH_CTRL = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic [BYTE_W-1:0] wrAddr;
    logic [BYTE_W-1:0] wrData;
    logic              rdLoad;
    logic [BYTE_W-1:0] rdAddr;
    logic              txShift;
    logic              txDrive;
  } strobe_t;
endpackage

// File: rtl/fspi_ctrl.sv
module fspi_ctrl
  import fspi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkIn,
  input  logic    nssIn,
  input  logic    mosiIn,
  output strobe_t stb
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclkSync, nssSync, mosiSync;
  logic sclkPrev, nssPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      nssSync  <= '1;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
      nssPrev  <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkIn};
      nssSync  <= {nssSync[SYNC_STAGES-2:0], nssIn};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
      nssPrev  <= nssSync[SYNC_STAGES-1];
    end
  end

  logic sclkS, nssS, mosiS;
  logic sclkRise, sclkFall, nssRise, nssFall;
  assign sclkS    = sclkSync[SYNC_STAGES-1];
  assign nssS     = nssSync[SYNC_STAGES-1];
  assign mosiS    = mosiSync[SYNC_STAGES-1];
  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign nssRise  = nssS & ~nssPrev;
  assign nssFall  = ~nssS & nssPrev;

  logic [CNT_W-1:0]  bitCnt;
  logic              overQ;
  logic [BYTE_W-1:0] rxShift, ctrlQ, addrQ;
  phase_e            phaseQ;
  logic              driveQ;

  logic resync, fullByte, cntDone, cidZero, readSel, writeSel;
  assign resync   = sclkRise & nssS;
  assign cntDone  = (bitCnt == CNT_W'(BYTE_W));
  assign fullByte = cntDone & ~overQ;
  assign cidZero  = (ctrlQ[CID_W-1:0] == '0);
  assign readSel  = ctrlQ[RW_BIT] & cidZero;
  assign writeSel = ~ctrlQ[RW_BIT] & (ctrlQ[BCAST_BIT] | cidZero);

  // bit capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      overQ   <= 1'b0;
      rxShift <= '0;
    end else if (nssFall) begin
      bitCnt <= '0;
      overQ  <= 1'b0;
    end else if (sclkRise && !nssS) begin
      if (!cntDone) begin
        rxShift <= {rxShift[BYTE_W-2:0], mosiS};
        bitCnt  <= bitCnt + 1'b1;
      end else begin
        overQ <= 1'b1;
      end
    end
  end

  // packet position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_CTRL;
      ctrlQ  <= '0;
      addrQ  <= '0;
      driveQ <= 1'b0;
    end else if (resync) begin
      phaseQ <= PH_CTRL;
      driveQ <= 1'b0;
    end else if (nssRise) begin
      driveQ <= 1'b0;
      unique case (phaseQ)
        PH_CTRL: if (fullByte) begin
          ctrlQ  <= rxShift;
          phaseQ <= PH_ADDR;
        end
        PH_ADDR: if (fullByte) begin
          addrQ  <= rxShift;
          phaseQ <= PH_DATA;
        end
        PH_DATA: if (cntDone) phaseQ <= PH_CTRL;
        default: phaseQ <= PH_CTRL;
      endcase
    end else if (nssFall && phaseQ == PH_DATA && readSel) begin
      driveQ <= 1'b1;
    end
  end

  always_comb begin
    stb         = '0;
    stb.wrEn    = nssRise & ~resync & (phaseQ == PH_DATA) & cntDone & writeSel;
    stb.wrAddr  = addrQ;
    stb.wrData  = rxShift;
    stb.rdLoad  = nssFall & (phaseQ == PH_DATA) & readSel;
    stb.rdAddr  = addrQ;
    stb.txShift = sclkFall & ~nssS & driveQ;
    stb.txDrive = driveQ;
  end

  assert_bitcnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));
  assert_phase_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ inside {PH_CTRL, PH_ADDR, PH_DATA});
  assert_resync_R3: assert property (@(posedge clk) disable iff (!rstN)
    resync |=> (phaseQ == PH_CTRL) && !driveQ);
  assert_drive_in_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    driveQ |-> phaseQ == PH_DATA);
  assert_drive_select_R7: assert property (@(posedge clk) disable iff (!rstN)
    driveQ |-> ctrlQ[RW_BIT] && ctrlQ[CID_W-1:0] == '0);
  assert_commit_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> phaseQ == PH_CTRL);
endmodule

// File: rtl/fspi_dp.sv
module fspi_dp
  import fspi_pkg::*;
#(
  parameter int NUM_CFG     = 4,
  parameter int CFG_BASE    = 1,
  parameter int STATUS_ADDR = 0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [BYTE_W-1:0]           chanStatus,
  output logic                        misoOut,
  output logic                        misoOe,
  output logic [NUM_CFG*BYTE_W-1:0]   cfgFlat
);
  logic [BYTE_W-1:0] cfgQ [NUM_CFG];
  logic [BYTE_W-1:0] txQ;
  logic [BYTE_W-1:0] readValue;
  logic              wrMapped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CFG; i++) cfgQ[i] <= '0;
    end else if (stb.wrEn) begin
      for (int i = 0; i < NUM_CFG; i++)
        if (stb.wrAddr == BYTE_W'(CFG_BASE + i)) cfgQ[i] <= stb.wrData;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CFG; g++) begin : gFlat
      assign cfgFlat[g*BYTE_W +: BYTE_W] = cfgQ[g];
    end
  endgenerate

  always_comb begin
    readValue = '0;
    if (stb.rdAddr == BYTE_W'(STATUS_ADDR)) readValue = chanStatus;
    for (int i = 0; i < NUM_CFG; i++)
      if (stb.rdAddr == BYTE_W'(CFG_BASE + i)) readValue = cfgQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txQ <= '0;
    else if (stb.rdLoad)  txQ <= readValue;
    else if (stb.txShift) txQ <= {txQ[BYTE_W-2:0], 1'b0};
  end

  assign misoOut = stb.txDrive ? txQ[BYTE_W-1] : 1'b0;
  assign misoOe  = stb.txDrive;

  assign wrMapped = (stb.wrAddr >= BYTE_W'(CFG_BASE)) &&
                    (stb.wrAddr <  BYTE_W'(CFG_BASE + NUM_CFG));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrEn |=> $stable(cfgFlat));
  assert_unmapped_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && !wrMapped) |=> $stable(cfgFlat));
  assert_no_shift_on_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rdLoad && stb.txShift));
endmodule

// File: rtl/framed_spi_regs.sv
module framed_spi_regs
  import fspi_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclkIn,
  input  logic                  nssIn,
  input  logic                  mosiIn,
  input  logic [NUM_CH-1:0]     chanStatus,
  output logic                  misoOut,
  output logic                  misoOe,
  output logic [2*NUM_CH-1:0]   modeCfg,
  output logic [2*NUM_CH-1:0]   dlyCfg
);
  localparam int PAIR_REGS = (2 * NUM_CH) / BYTE_W;
  localparam int NUM_CFG   = 2 * PAIR_REGS;

  strobe_t                    stb;
  logic [NUM_CFG*BYTE_W-1:0]  cfgFlat;

  fspi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclkIn (sclkIn),
    .nssIn  (nssIn),
    .mosiIn (mosiIn),
    .stb    (stb)
  );

  fspi_dp #(.NUM_CFG(NUM_CFG), .CFG_BASE(1), .STATUS_ADDR(0)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .chanStatus (chanStatus),
    .misoOut    (misoOut),
    .misoOe     (misoOe),
    .cfgFlat    (cfgFlat)
  );

  assign modeCfg = cfgFlat[2*NUM_CH-1:0];
  assign dlyCfg  = cfgFlat[4*NUM_CH-1:2*NUM_CH];
endmodule

// File: tb/sim_framed_spi_regs.sv
module sim_framed_spi_regs;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, nssIn = 1'b1, mosiIn = 1'b0;
  logic [7:0] chanStatus = 8'h00;
  logic misoOut, misoOe;
  logic [15:0] modeCfg, dlyCfg;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] mdl [4];

  always #2 clk = ~clk;

  framed_spi_regs u0 (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .nssIn(nssIn), .mosiIn(mosiIn),
    .chanStatus(chanStatus), .misoOut(misoOut), .misoOe(misoOe),
    .modeCfg(modeCfg), .dlyCfg(dlyCfg)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [7:0] a);
    if (a == 8'd0) return chanStatus;
    if (a >= 8'd1 && a <= 8'd4) return mdl[a - 8'd1];
    return 8'h00;
  endfunction

  function automatic logic [31:0] expCfg();
    return {mdl[3], mdl[2], mdl[1], mdl[0]};
  endfunction

  task automatic spiByte(input logic [7:0] b, input int edges,
                         output logic [7:0] got, output logic oeAny);
    got = 8'h00;
    oeAny = 1'b0;
    nssIn = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < edges; i++) begin
      mosiIn = (i < 8) ? b[7 - i] : 1'b0;
      waitClk(HALF);
      got = {got[6:0], misoOut};
      oeAny = oeAny | misoOe;
      sclkIn = 1'b1;
      waitClk(HALF);
      sclkIn = 1'b0;
    end
    waitClk(HALF);
    oeAny = oeAny | misoOe;
    nssIn = 1'b1;
    waitClk(2 * HALF);
  endtask

  task automatic resyncPulse();
    sclkIn = 1'b1;
    waitClk(HALF);
    sclkIn = 1'b0;
    waitClk(HALF);
  endtask

  task automatic packet(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] got, output logic oeHdr, output logic oeData);
    logic [7:0] g0;
    logic o0, o1;
    spiByte(c, 8, g0, o0);
    spiByte(a, 8, g0, o1);
    oeHdr = o0 | o1;
    spiByte(d, 8, got, oeData);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] got, g;
    logic oeH, oeD, o;
    logic [7:0] rdList [12];
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
    rdList = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd16, 8'd128, 8'd200, 8'd255};

    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    // R1 reset state
    chk("R1 cfg after reset", {dlyCfg, modeCfg}, 32'h0);
    chk("R1 oe after reset", misoOe, 1'b0);

    // R4 R6 write each mapped index, device 0
    for (int a = 1; a <= 4; a++) begin
      logic [7:0] v;
      v = 8'(8'h11 * a) ^ 8'hA5;
      packet(8'h00, 8'(a), v, got, oeH, oeD);
      mdl[a - 1] = v;
      chk("R4 cfg after write", {dlyCfg, modeCfg}, expCfg());
      chk("R6 oe during write", oeH | oeD, 1'b0);
    end
    // R4 channel pair positions: mode index 2 holds channels 7..4
    chk("R4 mode ch4 pair", modeCfg[9:8], mdl[1][1:0]);
    chk("R4 delay ch3 pair", dlyCfg[7:6], mdl[2][7:6]);

    // R4 R5 R6 R10 read sweep with two status patterns
    for (int s = 0; s < 2; s++) begin
      chanStatus = (s == 0) ? 8'h5C : 8'hA3;
      for (int k = 0; k < 12; k++) begin
        packet(8'h40, rdList[k], 8'h00, got, oeH, oeD);
        chk("R4 R5 R10 read value", got, expRead(rdList[k]));
        chk("R6 oe in header", oeH, 1'b0);
        chk("R6 oe in read data", oeD, 1'b1);
        chk("R6 oe after packet", misoOe, 1'b0);
      end
    end

    // R5 writes to read-only and unmapped indices
    foreach (rdList[k]) begin
      if (rdList[k] == 8'd0 || rdList[k] > 8'd4) begin
        packet(8'h00, rdList[k], 8'hFF, got, oeH, oeD);
        chk("R5 unmapped write", {dlyCfg, modeCfg}, expCfg());
      end
    end

    // R7 write select sweep; reserved bits 5:4 set on odd IDs
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 16; c++) begin
        logic [7:0] ctl, ad, dt;
        ctl = {1'(b), 1'b0, (c % 2 == 1) ? 2'b11 : 2'b00, 4'(c)};
        ad = 8'(1 + (c % 4));
        dt = {4'(c), 3'(b), 1'b1} ^ 8'h3C;
        packet(ctl, ad, dt, got, oeH, oeD);
        if (b == 1 || c == 0) mdl[ad - 1] = dt;
        chk("R7 write select", {dlyCfg, modeCfg}, expCfg());
      end
    end

    // R7 read select sweep, broadcast ignored on reads
    chanStatus = 8'h96;
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 16; c++) begin
        logic [7:0] ctl;
        ctl = {1'(b), 1'b1, 2'b00, 4'(c)};
        packet(ctl, 8'(c % 5), 8'h00, got, oeH, oeD);
        chk("R7 read drive", oeD, (c == 0) ? 1'b1 : 1'b0);
        if (c == 0) chk("R7 read value", got, expRead(8'(c % 5)));
      end
    end

    // R2 short command byte discarded
    spiByte(8'h40, 5, g, o);
    packet(8'h00, 8'h02, 8'hC3, got, oeH, oeD);
    mdl[1] = 8'hC3;
    chk("R2 short command discarded", {dlyCfg, modeCfg}, expCfg());
    // R2 long index byte discarded, next byte is the index
    spiByte(8'h00, 8, g, o);
    spiByte(8'h03, 9, g, o);
    spiByte(8'h02, 8, g, o);
    spiByte(8'h3C, 8, g, o);
    mdl[1] = 8'h3C;
    chk("R2 long index discarded", {dlyCfg, modeCfg}, expCfg());

    // R3 resync between index and payload
    spiByte(8'h00, 8, g, o);
    spiByte(8'h01, 8, g, o);
    resyncPulse();
    packet(8'h00, 8'h04, 8'h77, got, oeH, oeD);
    mdl[3] = 8'h77;
    chk("R3 resync abandons packet", {dlyCfg, modeCfg}, expCfg());
    // R3 resync mid read header, then a clean read
    spiByte(8'h40, 8, g, o);
    resyncPulse();
    packet(8'h40, 8'h04, 8'h00, got, oeH, oeD);
    chk("R3 read after resync", got, 8'h77);

    // R8 short payload leaves register unchanged
    spiByte(8'h00, 8, g, o);
    spiByte(8'h03, 8, g, o);
    spiByte(8'hE1, 5, g, o);
    chk("R8 short payload no write", {dlyCfg, modeCfg}, expCfg());
    resyncPulse();
    chk("R8 still unchanged after resync", {dlyCfg, modeCfg}, expCfg());

    // R9 long payload commits first eight bits
    spiByte(8'h80, 8, g, o);
    spiByte(8'h03, 8, g, o);
    spiByte(8'h96, 11, g, o);
    mdl[2] = 8'h96;
    chk("R9 long payload commits", {dlyCfg, modeCfg}, expCfg());
    packet(8'h40, 8'h03, 8'h00, got, oeH, oeD);
    chk("R9 R10 readback", got, 8'h96);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule